// File: doc/BRIEF.md
# Real-Time Clock Status and Interrupt Registers

This block holds the control and status registers of a CMOS-style real-time clock, together with the interrupt logic behind them. Its time base is a single-cycle enable that pulses at 32.768 kHz. Software reaches four registers (A, B, C and D) through a byte interface with two ports. It writes an index to the index port, and then reads or writes the selected register through the data port.

The block raises two interrupt sources. The periodic source taps a free-running binary divider at a point chosen by a 4-bit rate code. The update-ended source fires once per second, when the one-second counter wraps. For a fixed window of base ticks before each update, a read-only update-in-progress flag is set. It tells software that the time fields must not be read yet.

The time base runs only while the divider-select field holds the run code. Register B stores the interrupt enables and the hour-format bit, which the calendar logic outside this block consumes. Register D reports the power-valid input. The interrupt line shows whether any enabled flag in register C is pending. Reading register C clears every flag.

Top module: `rtc_status_regs`

## Requirements
- R1: After reset, registers A, B and C read 0x00 and `irq` is low.
- R2: Register D (index 0x0D) reads `{pwr_ok, 7'b0}`. Writes to it have no effect.
- R3: Register B (index 0x0B) stores all eight written bits and reads them back. Bit 6 is the periodic enable, bit 4 the update-ended enable and bit 1 the hour format (1 = 24-hour).
- R4: While register A (index 0x0A) bits 6-4 differ from 3'b010, no periodic or update-ended flag is ever set.
- R5: With a nonzero rate code r in A bits 3-0, the periodic flag (C bit 6) is set every 2^(r-1) base ticks. Codes 1 and 2 behave as codes 8 and 9 (128 and 256 ticks).
- R6: Rate code 0 never sets the periodic flag.
- R7: While running, the update-ended flag (C bit 4) is set once every SECOND_TICKS base ticks.
- R8: Register A bit 7 reads 1 for exactly UIP_TICKS base ticks before each update and 0 otherwise. Writes to that bit are ignored.
- R9: Register C (index 0x0C) bit 7 and `irq` equal the OR of each flag ANDed with its enable. A flag is still set while its enable is 0.
- R10: A data-port read of register C returns the flags and clears all of them, so `irq` is low on the following cycle unless a new event arrives.
- R11: While `tick_en` is low, no flag is set and the dividers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | 32.768 kHz time-base enable, one cycle wide |
| pwr_ok | input | 1 | Power-valid status, reported in register D bit 7 |
| cs | input | 1 | Bus access strobe |
| we | input | 1 | 1 = write, 0 = read |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected port |
| irq | output | 1 | Interrupt request, active high |

## Verification
On every cycle, the assertions check the following. No event happens while the time base is stopped or the enable is low. Rate code 0 gives no periodic event. Each update falls inside the update-in-progress window. An update always leaves its flag set. A register C read drops the interrupt. The reserved bits of D read as zero. Only the bench's scenarios can show the periodic intervals for each rate code, including the aliased codes. They also show the one-second interval, the exact length of the update-in-progress window, and how flag and enable combine in register C.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;
   localparam logic [6:0] IDX_A = 7'h0A;
   localparam logic [6:0] IDX_B = 7'h0B;
   localparam logic [6:0] IDX_C = 7'h0C;
   localparam logic [6:0] IDX_D = 7'h0D;
   localparam logic [2:0] DIV_RUN = 3'b010;
   localparam int unsigned MAX_TAP = 14;

   // Low codes alias to slower taps; others map straight through.
   function automatic logic [3:0] eff_rate(input logic [3:0] code);
      case (code)
         4'd1:    eff_rate = 4'd8;
         4'd2:    eff_rate = 4'd9;
         default: eff_rate = code;
      endcase
   endfunction
endpackage

// File: rtl/rtc_rate_divider.sv
module rtc_rate_divider
   import rtc_stat_pkg::*;
#(
   parameter int unsigned PRE_W = 14
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       run,
   input  logic [3:0] rate,
   output logic       evt
);
   generate
      if (PRE_W < MAX_TAP) begin : g_bad_width
         $error("rtc_rate_divider: PRE_W must cover the slowest tap");
      end
   endgenerate

   logic [PRE_W-1:0] pre;
   logic [15:0]      ones;
   logic [3:0]       tap;

   // ones[j] is high when the low j bits of the divider are all set
   for (genvar j = 0; j < 16; j++) begin : g_tap
      if (j == 0) begin : g_zero
         assign ones[j] = 1'b1;
      end else if (j <= PRE_W) begin : g_live
         assign ones[j] = &pre[j-1:0];
      end else begin : g_none
         assign ones[j] = 1'b0;
      end
   end

   assign tap = eff_rate(rate) - 4'd1;
   assign evt = run && tick_en && (rate != 4'd0) && ones[tap];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre <= '0;
      else if (!run)    pre <= '0;
      else if (tick_en) pre <= pre + PRE_W'(1);
   end
endmodule

// File: rtl/rtc_second_timer.sv
module rtc_second_timer #(
   parameter int unsigned SECOND_TICKS = 32768,
   parameter int unsigned UIP_TICKS    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic run,
   output logic upd,
   output logic uip
);
   localparam int unsigned CW = $clog2(SECOND_TICKS);
   localparam logic [CW-1:0] LAST      = CW'(SECOND_TICKS - 1);
   localparam logic [CW-1:0] UIP_START = CW'(SECOND_TICKS - UIP_TICKS);

   generate
      if (UIP_TICKS == 0 || UIP_TICKS >= SECOND_TICKS) begin : g_bad_uip
         $error("rtc_second_timer: UIP_TICKS out of range");
      end
      if (SECOND_TICKS < 4) begin : g_bad_sec
         $error("rtc_second_timer: SECOND_TICKS too small");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign upd = run && tick_en && (cnt == LAST);
   assign uip = run && (cnt >= UIP_START);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!run)    cnt <= '0;
      else if (tick_en) cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
   end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic per_evt,
   input  logic upd_evt,
   input  logic clr,
   input  logic pie,
   input  logic uie,
   output logic pf,
   output logic uf,
   output logic irq
);
   // A new event outranks a clearing read in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf <= 1'b0;
         uf <= 1'b0;
      end else begin
         pf <= per_evt | (pf & ~clr);
         uf <= upd_evt | (uf & ~clr);
      end
   end

   assign irq = (pf & pie) | (uf & uie);
endmodule

// File: rtl/rtc_status_regs.sv
module rtc_status_regs
   import rtc_stat_pkg::*;
#(
   parameter int unsigned SECOND_TICKS = 32768,
   parameter int unsigned UIP_TICKS    = 8,
   parameter int unsigned PRE_W        = 14
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       pwr_ok,
   input  logic       cs,
   input  logic       we,
   input  logic       port_sel,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       irq
);
   logic [6:0] idx;
   logic [2:0] a_div;
   logic [3:0] a_rate;
   logic [7:0] b_reg;
   logic       running, per_evt, upd_evt, uip, pf, uf;
   logic       wr_idx, wr_dat, rd_dat, rd_c_stb;

   assign wr_idx   = cs && we && !port_sel;
   assign wr_dat   = cs && we && port_sel;
   assign rd_dat   = cs && !we && port_sel;
   assign rd_c_stb = rd_dat && (idx == IDX_C);
   assign running  = (a_div == DIV_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx    <= '0;
         a_div  <= '0;
         a_rate <= '0;
         b_reg  <= '0;
      end else begin
         if (wr_idx) idx <= wdata[6:0];
         if (wr_dat && idx == IDX_A) begin
            a_div  <= wdata[6:4];
            a_rate <= wdata[3:0];
         end
         if (wr_dat && idx == IDX_B) b_reg <= wdata;
      end
   end

   rtc_rate_divider #(.PRE_W(PRE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(running),
      .rate(a_rate), .evt(per_evt)
   );

   rtc_second_timer #(.SECOND_TICKS(SECOND_TICKS), .UIP_TICKS(UIP_TICKS)) u_sec (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(running),
      .upd(upd_evt), .uip(uip)
   );

   rtc_irq_flags u_flags (
      .clk(clk), .rst_n(rst_n), .per_evt(per_evt), .upd_evt(upd_evt),
      .clr(rd_c_stb), .pie(b_reg[6]), .uie(b_reg[4]),
      .pf(pf), .uf(uf), .irq(irq)
   );

   always_comb begin
      rdata = 8'h00;
      if (!port_sel) begin
         rdata = {1'b0, idx};
      end else begin
         case (idx)
            IDX_A:   rdata = {uip, a_div, a_rate};
            IDX_B:   rdata = b_reg;
            IDX_C:   rdata = {irq, pf, 1'b0, uf, 4'h0};
            IDX_D:   rdata = {pwr_ok, 7'h00};
            default: rdata = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/rtc_status_regs_chk.sv
module rtc_status_regs_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_en,
   input logic       running,
   input logic       per_evt,
   input logic       upd_evt,
   input logic       uip,
   input logic       rd_c_stb,
   input logic       uf,
   input logic       irq,
   input logic [3:0] a_rate,
   input logic [6:0] idx,
   input logic       port_sel,
   input logic [7:0] rdata
);
   AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !per_evt && !upd_evt); // R4
   AST_RATE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rate == 4'd0) |-> !per_evt); // R6
   AST_UPD_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      upd_evt |=> uf); // R7
   AST_UPD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      upd_evt |-> uip); // R8
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_c_stb && !per_evt && !upd_evt) |=> !irq); // R10
   AST_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |-> !per_evt && !upd_evt); // R11
   AST_D_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (port_sel && idx == 7'h0D) |-> (rdata[6:0] == 7'h00)); // R2
endmodule

bind rtc_status_regs rtc_status_regs_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .running(running),
   .per_evt(per_evt), .upd_evt(upd_evt), .uip(uip), .rd_c_stb(rd_c_stb),
   .uf(uf), .irq(irq), .a_rate(a_rate), .idx(idx), .port_sel(port_sel),
   .rdata(rdata)
);

// File: tb/rtc_status_regs_test.sv
module rtc_status_regs_test;
   localparam int CLK_PERIOD = 10;
   localparam int SEC = 64;
   localparam int UIPW = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic       pwr_ok = 1'b1;
   logic       cs = 1'b0, we = 1'b0, port_sel = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq;
   int         checks = 0, errors = 0, cyc = 0;

   rtc_status_regs #(.SECOND_TICKS(SEC), .UIP_TICKS(UIPW)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwr_ok(pwr_ok),
      .cs(cs), .we(we), .port_sel(port_sel), .wdata(wdata),
      .rdata(rdata), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic set_idx(input logic [6:0] i);
      @(negedge clk); cs = 1; we = 1; port_sel = 0; wdata = {1'b0, i};
      @(negedge clk); cs = 0; we = 0;
   endtask

   task automatic wr_reg(input logic [6:0] i, input logic [7:0] v);
      set_idx(i);
      @(negedge clk); cs = 1; we = 1; port_sel = 1; wdata = v;
      @(negedge clk); cs = 0; we = 0;
   endtask

   task automatic rd_data(output logic [7:0] v);
      @(negedge clk); cs = 1; we = 0; port_sel = 1;
      #1 v = rdata;
      @(negedge clk); cs = 0;
   endtask

   task automatic rd_reg(input logic [6:0] i, output logic [7:0] v);
      set_idx(i);
      rd_data(v);
   endtask

   task automatic wait_irq(output bit ok);
      ok = 0;
      for (int n = 0; n < 20000; n++) begin
         @(negedge clk);
         if (irq) begin ok = 1; break; end
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic test_reset;
      logic [7:0] v;
      check("R1 irq", irq, 0);
      rd_reg(7'h0A, v); check("R1 regA", v, 8'h00);
      rd_reg(7'h0B, v); check("R1 regB", v, 8'h00);
      rd_reg(7'h0C, v); check("R1 regC", v, 8'h00);
   endtask

   task automatic test_power;
      logic [7:0] v;
      wr_reg(7'h0D, 8'h7F);
      rd_reg(7'h0D, v); check("R2 regD pwr=1", v, 8'h80);
      pwr_ok = 0;
      rd_reg(7'h0D, v); check("R2 regD pwr=0", v, 8'h00);
      pwr_ok = 1;
   endtask

   task automatic test_regb;
      logic [7:0] v;
      wr_reg(7'h0B, 8'h5A);
      rd_reg(7'h0B, v); check("R3 regB 0x5A", v, 8'h5A);
      wr_reg(7'h0B, 8'h02);
      rd_reg(7'h0B, v); check("R3 regB hour24", v, 8'h02);
      wr_reg(7'h0A, 8'h80);
      rd_reg(7'h0A, v); check("R8 uip bit write ignored", v, 8'h00);
   endtask

   task automatic test_stopped;
      logic [7:0] v;
      wr_reg(7'h0B, 8'h50);
      wr_reg(7'h0A, 8'h03);
      idle(200);
      rd_reg(7'h0C, v); check("R4 div 000 no flags", v, 8'h00);
      wr_reg(7'h0A, 8'h33);
      idle(200);
      rd_reg(7'h0C, v); check("R4 div 011 no flags", v, 8'h00);
      check("R4 irq low", irq, 0);
   endtask

   task automatic test_rate(input logic [3:0] r, input int exp);
      logic [7:0] v;
      bit ok;
      int t1, t2;
      wr_reg(7'h0B, 8'h40);
      wr_reg(7'h0A, {4'h2, r});
      set_idx(7'h0C);
      wait_irq(ok); rd_data(v);
      wait_irq(ok); t1 = cyc; rd_data(v);
      wait_irq(ok); t2 = cyc; rd_data(v);
      check($sformatf("R5 period code %0d", r), ok ? t2 - t1 : -1, exp);
   endtask

   task automatic test_rate0;
      logic [7:0] v;
      wr_reg(7'h0B, 8'h40);
      wr_reg(7'h0A, 8'h20);
      rd_reg(7'h0C, v);
      idle(300);
      rd_reg(7'h0C, v); check("R6 rate 0 no periodic flag", v & 8'h40, 0);
   endtask

   task automatic test_update;
      logic [7:0] v;
      bit ok;
      int c1, c2, c3;
      wr_reg(7'h0B, 8'h00);
      wr_reg(7'h0A, 8'h20);
      rd_reg(7'h0C, v);
      set_idx(7'h0A);
      @(negedge clk); cs = 1; we = 0; port_sel = 1;
      c1 = 0; c2 = 0; c3 = 0;
      for (int n = 0; n < 500; n++) begin @(negedge clk); if (rdata[7]) begin c1 = cyc; break; end end
      for (int n = 0; n < 500; n++) begin @(negedge clk); if (!rdata[7]) begin c2 = cyc; break; end end
      for (int n = 0; n < 500; n++) begin @(negedge clk); if (rdata[7]) begin c3 = cyc; break; end end
      cs = 0;
      check("R8 uip window length", c2 - c1, UIPW);
      check("R7 update interval", c3 - c1, SEC);
      set_idx(7'h0C);
      rd_data(v); check("R9 uf set while disabled", v, 8'h10);
      check("R9 irq low when disabled", irq, 0);
      wr_reg(7'h0B, 8'h10);
      set_idx(7'h0C);
      wait_irq(ok);
      check("R9 irq with uie", ok, 1);
      rd_data(v); check("R9 regC enabled flag", v, 8'h90);
      check("R10 irq low after read", irq, 0);
   endtask

   task automatic test_freeze;
      logic [7:0] v;
      wr_reg(7'h0B, 8'h50);
      wr_reg(7'h0A, 8'h23);
      tick_en = 0;
      idle(2);
      rd_reg(7'h0C, v);
      idle(200);
      rd_reg(7'h0C, v); check("R11 no flags while tick low", v, 8'h00);
      check("R11 irq low", irq, 0);
      tick_en = 1;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      test_reset;
      test_power;
      test_regb;
      test_stopped;
      test_rate(4'd3, 4);
      test_rate(4'd6, 32);
      test_rate(4'd1, 128);
      test_rate(4'd2, 256);
      test_rate(4'd15, 16384);
      test_rate0;
      test_update;
      test_freeze;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule